// File: doc/BRIEF.md
# Verification-Guided Error Correction Searcher

This block repairs a 512-bit memory block by trial and recheck. It does not decode an error-correcting code. A block enters as two 256-bit beats. Each beat carries the stored 4-bit interleaved parity of its half. The block first sends the block unchanged to an external integrity-check port. If that check passes, the block is handed on as it is and no search runs. If the check fails, the block proposes candidate repairs one at a time and rechecks each one. It stops at the first candidate that passes, or when the candidate space for the selected mode is used up.

There are two search modes, chosen per block:
- **Bit mode** inverts one bit per candidate.
- **Chip mode** assumes that one 4-bit memory-chip lane per half may be wrong in any subset of its bits. The parity syndrome of a half gives the exact flip pattern, so only the lane position is searched.

For hard faults, every search first tries the location that fixed the previous block in the same mode.

Input and output are valid/ready streams:
- A beat moves on a cycle where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source holds the beat.
- The result is offered on `out_valid` and stays unchanged until `out_ready` is high.
- No new block is accepted until the result has been taken.

The check port carries one request at a time: a one-cycle `chk_req` pulse, then a response of any latency.

Top module: `chk_guided_corrector`

## Requirements
- R1: A block is two beats, the first forming bits 255:0 and the second bits 511:256. The mode (`in_mode`, 0 = bit, 1 = chip) is taken from the first beat. `in_ready` is high after reset and is low from the second accepted beat until the result has been taken.
- R2: The first check request of every block carries the block exactly as received. If it passes, the result is that block with `out_uncorr` = 0 and `out_attempts` = 0, and no further request is issued.
- R3: In bit mode, each candidate is the received block with exactly one bit inverted. Normal order is bit 0 upward, and there are at most 512 candidates.
- R4: In chip mode, lane l of a half is bits 4l+3..4l of that half. Parity bit j is the XOR of bit j of all 64 lanes. A half's syndrome is its stored parity XOR the parity computed from the received half. A candidate XORs each non-zero syndrome into one lane of its half; a half with a zero syndrome is left untouched. With one non-zero half, lane order is 0..63. With both non-zero, index k = 64a+b selects lane a of the first half and lane b of the second, k running 0..4095.
- R5: In chip mode, a failed first check with both syndromes zero ends at once as uncorrectable, with 0 attempts.
- R6: Each mode has a start hint, which reset clears. In bit mode the hint is the bit index. In chip mode it is the lane of the first non-zero half, and with both halves non-zero it is applied as the pair (hint, hint). The hint is written only by a successful correction. When valid, it is the first candidate tried, and it is skipped when normal order reaches it.
- R7: When the candidate space is exhausted, `out_uncorr` = 1 and `out_data` is the block as received.
- R8: On a passing candidate, `out_data` is that candidate, `out_uncorr` = 0, and `out_attempts` counts the candidate checks, excluding the first check of the received block.
- R9: `chk_req` is a one-cycle pulse, and only one request is outstanding at a time. `chk_data` is held until `chk_rsp_valid` arrives, whatever the latency.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_uncorr` and `out_attempts` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_data | input | 256 | Beat data (first beat = low half) |
| in_par | input | 4 | Stored parity of this beat's half |
| in_mode | input | 1 | Search mode, sampled with the first beat |
| chk_req | output | 1 | Integrity-check request pulse |
| chk_data | output | 512 | Block under check |
| chk_rsp_valid | input | 1 | Check response strobe |
| chk_rsp_pass | input | 1 | Check result, valid with chk_rsp_valid |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_data | output | 512 | Corrected or original block |
| out_uncorr | output | 1 | High when no candidate passed |
| out_attempts | output | 16 | Number of candidate checks |

## Verification
The assertions assume the following of the check port:
- `chk_rsp_valid` is raised only while a request is outstanding, and at most once per request.
- A source holds a beat stable while it waits for `in_ready`.

The bench's check stub answers each request exactly once, after 4 to 8 cycles, by comparing `chk_data` with the intact block. It flags any request that arrives while another is outstanding. Beats are driven stable until accepted, sometimes with idle gaps between them. The result is held back for several cycles before `out_ready` is raised, which exercises the hold rule.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic {SRCH_BIT = 1'b0, SRCH_CHIP = 1'b1} srch_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_state_e;
endpackage

// File: rtl/cgc_assembler.sv
module cgc_assembler
  import cgc_pkg::*;
#(
  parameter int BEAT_W = 256,
  parameter int LANE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BEAT_W-1:0]     in_data,
  input  logic [LANE_W-1:0]     in_par,
  input  logic                  in_mode,
  input  logic                  release_i,
  output logic                  full_o,
  output srch_mode_e            mode_o,
  output logic [2*BEAT_W-1:0]   blk_o,
  output logic [LANE_W-1:0]     syn0_o,
  output logic [LANE_W-1:0]     syn1_o
);
  localparam int LANES = BEAT_W / LANE_W;
  localparam int BLK_W = 2 * BEAT_W;

  logic              beat_hi;
  logic              take;
  logic [LANE_W-1:0] par_calc;

  // interleaved parity: bit j folds bit j of every lane
  always_comb begin
    par_calc = '0;
    for (int l = 0; l < LANES; l++) par_calc ^= in_data[l*LANE_W +: LANE_W];
  end

  assign in_ready = !full_o;
  assign take     = in_valid && !full_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_hi <= 1'b0;
      full_o  <= 1'b0;
      blk_o   <= '0;
      syn0_o  <= '0;
      syn1_o  <= '0;
      mode_o  <= SRCH_BIT;
    end else begin
      if (release_i) full_o <= 1'b0;
      if (take) begin
        if (!beat_hi) begin
          blk_o[BEAT_W-1:0] <= in_data;
          syn0_o            <= in_par ^ par_calc;
          mode_o            <= srch_mode_e'(in_mode);
          beat_hi           <= 1'b1;
        end else begin
          blk_o[BLK_W-1:BEAT_W] <= in_data;
          syn1_o                <= in_par ^ par_calc;
          beat_hi               <= 1'b0;
          full_o                <= 1'b1;
        end
      end
    end
  end

  // R1: a held block accepts no beat until released
  assert_no_beat_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !release_i) |=> full_o && $stable(blk_o));
endmodule

// File: rtl/cgc_candidate.sv
module cgc_candidate
  import cgc_pkg::*;
#(
  parameter int BEAT_W = 256,
  parameter int LANE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 probe_i,
  input  srch_mode_e           mode_i,
  input  logic                 use_orig_i,
  input  logic [LANE_W-1:0]    syn0_i,
  input  logic [LANE_W-1:0]    syn1_i,
  input  logic [CNT_W-1:0]     idx_i,
  input  logic [2*BEAT_W-1:0]  orig_i,
  output logic [2*BEAT_W-1:0]  cand_o
);
  localparam int LANES = BEAT_W / LANE_W;
  localparam int LB    = $clog2(LANES);
  localparam int BLK_W = 2 * BEAT_W;

  logic             nz0, nz1, both;
  logic [LB-1:0]    lane_a, lane_b;
  logic [BLK_W-1:0] bit_mask, lane_mask, mask;

  assign nz0    = |syn0_i;
  assign nz1    = |syn1_i;
  assign both   = nz0 && nz1;
  assign lane_a = both ? idx_i[2*LB-1:LB] : idx_i[LB-1:0];
  assign lane_b = idx_i[LB-1:0];

  for (genvar b = 0; b < BLK_W; b++) begin : g_bit
    assign bit_mask[b] = (idx_i == CNT_W'(b));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] =
      (nz0 && lane_a == LB'(l)) ? syn0_i : '0;
    assign lane_mask[BEAT_W + l*LANE_W +: LANE_W] =
      (nz1 && lane_b == LB'(l)) ? syn1_i : '0;
  end

  always_comb begin
    if (use_orig_i)              mask = '0;
    else if (mode_i == SRCH_BIT) mask = bit_mask;
    else                         mask = lane_mask;
  end

  assign cand_o = orig_i ^ mask;

  // R3: a bit-mode candidate differs from the received block in one bit
  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_i && !use_orig_i && mode_i == SRCH_BIT) |-> $countones(cand_o ^ orig_i) == 1);

  // R4: a chip-mode candidate flips exactly the syndrome bits
  assert_lane_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_i && !use_orig_i && mode_i == SRCH_CHIP) |->
      $countones(cand_o ^ orig_i) == ($countones(syn0_i) + $countones(syn1_i)));

  // R2: the first check carries the block unchanged
  assert_first_unchanged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_i && use_orig_i) |-> cand_o == orig_i);
endmodule

// File: rtl/cgc_sequencer.sv
module cgc_sequencer
  import cgc_pkg::*;
#(
  parameter int BEAT_W = 256,
  parameter int LANE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 full_i,
  input  srch_mode_e           mode_i,
  input  logic [LANE_W-1:0]    syn0_i,
  input  logic [LANE_W-1:0]    syn1_i,
  input  logic [2*BEAT_W-1:0]  orig_i,
  input  logic [2*BEAT_W-1:0]  cand_i,
  output logic                 chk_req_o,
  input  logic                 chk_rsp_valid_i,
  input  logic                 chk_rsp_pass_i,
  output logic [CNT_W-1:0]     idx_o,
  output logic                 use_orig_o,
  output logic                 release_o,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [2*BEAT_W-1:0]  out_data_o,
  output logic                 out_uncorr_o,
  output logic [CNT_W-1:0]     out_attempts_o
);
  localparam int LANES  = BEAT_W / LANE_W;
  localparam int LB     = $clog2(LANES);
  localparam int BLK_W  = 2 * BEAT_W;
  localparam int BIT_IW = $clog2(BLK_W);
  localparam int PAIRS  = LANES * LANES;

  sq_state_e        state;
  logic             init_q, hint_q, hused_q;
  logic [CNT_W-1:0] attempts;
  logic [BIT_IW-1:0] hb_q;
  logic             hb_v;
  logic [LB-1:0]    hl_q;
  logic             hl_v;

  logic             nz0, nz1, both, hint_v, exhausted;
  logic [CNT_W-1:0] n_cand, hint_idx, step_base, nxt;
  logic [LB-1:0]    hit_lane;

  assign nz0  = |syn0_i;
  assign nz1  = |syn1_i;
  assign both = nz0 && nz1;

  always_comb begin
    if (mode_i == SRCH_BIT) n_cand = CNT_W'(BLK_W);
    else if (both)          n_cand = CNT_W'(PAIRS);
    else if (nz0 || nz1)    n_cand = CNT_W'(LANES);
    else                    n_cand = '0;
  end

  assign hint_v = (mode_i == SRCH_BIT) ? hb_v : hl_v;

  always_comb begin
    if (mode_i == SRCH_BIT) hint_idx = CNT_W'(hb_q);
    else if (both)          hint_idx = CNT_W'({hl_q, hl_q});
    else                    hint_idx = CNT_W'(hl_q);
  end

  // next index in normal order, stepping over the already-tried hint
  assign step_base = hint_q ? '0 : idx_o + CNT_W'(1);
  assign nxt       = (hused_q && step_base == hint_idx) ? step_base + CNT_W'(1) : step_base;
  assign exhausted = (nxt >= n_cand);
  assign hit_lane  = both ? idx_o[2*LB-1:LB] : idx_o[LB-1:0];

  assign chk_req_o      = (state == SQ_ISSUE);
  assign out_valid_o    = (state == SQ_DONE);
  assign release_o      = (state == SQ_DONE) && out_ready_i;
  assign use_orig_o     = init_q;
  assign out_attempts_o = attempts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SQ_IDLE;
      init_q       <= 1'b0;
      hint_q       <= 1'b0;
      hused_q      <= 1'b0;
      idx_o        <= '0;
      attempts     <= '0;
      hb_q         <= '0;
      hb_v         <= 1'b0;
      hl_q         <= '0;
      hl_v         <= 1'b0;
      out_data_o   <= '0;
      out_uncorr_o <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (full_i) begin
          init_q   <= 1'b1;
          hint_q   <= 1'b0;
          hused_q  <= 1'b0;
          idx_o    <= '0;
          attempts <= '0;
          state    <= SQ_ISSUE;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (chk_rsp_valid_i) begin
          if (!init_q) attempts <= attempts + CNT_W'(1);
          if (chk_rsp_pass_i) begin
            out_data_o   <= cand_i;
            out_uncorr_o <= 1'b0;
            state        <= SQ_DONE;
            if (!init_q) begin
              if (mode_i == SRCH_BIT) begin
                hb_q <= idx_o[BIT_IW-1:0];
                hb_v <= 1'b1;
              end else begin
                hl_q <= hit_lane;
                hl_v <= 1'b1;
              end
            end
          end else if (init_q) begin
            init_q <= 1'b0;
            if (n_cand == '0) begin
              out_data_o   <= orig_i;
              out_uncorr_o <= 1'b1;
              state        <= SQ_DONE;
            end else if (hint_v) begin
              hint_q  <= 1'b1;
              hused_q <= 1'b1;
              idx_o   <= hint_idx;
              state   <= SQ_ISSUE;
            end else begin
              idx_o <= '0;
              state <= SQ_ISSUE;
            end
          end else begin
            hint_q <= 1'b0;
            if (exhausted) begin
              out_data_o   <= orig_i;
              out_uncorr_o <= 1'b1;
              state        <= SQ_DONE;
            end else begin
              idx_o <= nxt;
              state <= SQ_ISSUE;
            end
          end
        end
        SQ_DONE: if (out_ready_i) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R9: request is a single-cycle pulse
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req_o |=> !chk_req_o);

  // R9: candidate held while its response is pending
  assert_req_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && !chk_rsp_valid_i) |=> $stable(cand_i));

  // R10: result holds under back-pressure
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      out_valid_o && $stable(out_data_o) && $stable(out_uncorr_o) && $stable(out_attempts_o));

  // R3: bit-mode search never exceeds the block width
  assert_bit_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && mode_i == SRCH_BIT) |-> out_attempts_o <= CNT_W'(BLK_W));

  // R4: chip-mode search never exceeds the pair space
  assert_chip_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && mode_i == SRCH_CHIP) |-> out_attempts_o <= CNT_W'(PAIRS));

  // R7: uncorrectable result returns the received block
  assert_unc_orig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_uncorr_o) |-> out_data_o == orig_i);
endmodule

// File: rtl/chk_guided_corrector.sv
module chk_guided_corrector
  import cgc_pkg::*;
#(
  parameter int BEAT_W = 256,
  parameter int LANE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BEAT_W-1:0]    in_data,
  input  logic [LANE_W-1:0]    in_par,
  input  logic                 in_mode,
  output logic                 chk_req,
  output logic [2*BEAT_W-1:0]  chk_data,
  input  logic                 chk_rsp_valid,
  input  logic                 chk_rsp_pass,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*BEAT_W-1:0]  out_data,
  output logic                 out_uncorr,
  output logic [CNT_W-1:0]     out_attempts
);
  localparam int BLK_W = 2 * BEAT_W;

  logic              full, release_w, use_orig;
  srch_mode_e        mode;
  logic [BLK_W-1:0]  orig;
  logic [LANE_W-1:0] syn0, syn1;
  logic [CNT_W-1:0]  idx;

  cgc_assembler #(.BEAT_W(BEAT_W), .LANE_W(LANE_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_par(in_par), .in_mode(in_mode),
    .release_i(release_w), .full_o(full), .mode_o(mode),
    .blk_o(orig), .syn0_o(syn0), .syn1_o(syn1)
  );

  cgc_candidate #(.BEAT_W(BEAT_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_cand (
    .clk(clk), .rst_n(rst_n), .probe_i(chk_req),
    .mode_i(mode), .use_orig_i(use_orig),
    .syn0_i(syn0), .syn1_i(syn1), .idx_i(idx),
    .orig_i(orig), .cand_o(chk_data)
  );

  cgc_sequencer #(.BEAT_W(BEAT_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .full_i(full), .mode_i(mode), .syn0_i(syn0), .syn1_i(syn1),
    .orig_i(orig), .cand_i(chk_data),
    .chk_req_o(chk_req), .chk_rsp_valid_i(chk_rsp_valid), .chk_rsp_pass_i(chk_rsp_pass),
    .idx_o(idx), .use_orig_o(use_orig), .release_o(release_w),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_uncorr_o(out_uncorr), .out_attempts_o(out_attempts)
  );

  // R1: no beat is taken while a result waits
  assert_busy_blocks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/test_chk_guided_corrector.sv
module test_chk_guided_corrector;
  localparam int BW = 256;
  localparam int NV = 16;

  typedef struct packed {
    logic        mode;
    logic [9:0]  pa;
    logic [3:0]  ka;
    logic [9:0]  pb;
    logic [3:0]  kb;
    logic [15:0] att;
    logic        unc;
  } vec_t;

  // error = pattern ka at bit pa XOR pattern kb at bit pb; expected attempts and flag
  localparam vec_t VTAB [NV] = '{
    '{1'b0, 10'd0,   4'h0, 10'd0,   4'h0, 16'd0,    1'b0},
    '{1'b0, 10'd37,  4'h1, 10'd0,   4'h0, 16'd38,   1'b0},
    '{1'b0, 10'd37,  4'h1, 10'd0,   4'h0, 16'd1,    1'b0},
    '{1'b0, 10'd5,   4'h1, 10'd0,   4'h0, 16'd7,    1'b0},
    '{1'b0, 10'd40,  4'h1, 10'd0,   4'h0, 16'd41,   1'b0},
    '{1'b0, 10'd511, 4'h1, 10'd0,   4'h0, 16'd512,  1'b0},
    '{1'b0, 10'd3,   4'h1, 10'd9,   4'h1, 16'd512,  1'b1},
    '{1'b1, 10'd40,  4'hB, 10'd0,   4'h0, 16'd11,   1'b0},
    '{1'b1, 10'd296, 4'h6, 10'd0,   4'h0, 16'd1,    1'b0},
    '{1'b1, 10'd12,  4'hF, 10'd336, 4'h1, 16'd214,  1'b0},
    '{1'b1, 10'd252, 4'h8, 10'd508, 4'h8, 16'd4096, 1'b0},
    '{1'b1, 10'd284, 4'h4, 10'd0,   4'h0, 16'd9,    1'b0},
    '{1'b1, 10'd0,   4'h0, 10'd0,   4'h0, 16'd0,    1'b0},
    '{1'b1, 10'd8,   4'h1, 10'd20,  4'h1, 16'd0,    1'b1},
    '{1'b1, 10'd8,   4'h1, 10'd20,  4'h2, 16'd64,   1'b1},
    '{1'b1, 10'd28,  4'hC, 10'd0,   4'h0, 16'd1,    1'b0}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [BW-1:0]  in_data = '0;
  logic [3:0]     in_par = '0;
  logic           in_mode = 1'b0;
  logic           chk_req;
  logic [2*BW-1:0] chk_data;
  logic           chk_rsp_valid = 1'b0;
  logic           chk_rsp_pass = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [2*BW-1:0] out_data;
  logic           out_uncorr;
  logic [15:0]    out_attempts;

  int nchk = 0;
  int nfail = 0;
  int nreq = 0;
  int overlap = 0;
  int lat_cur = 4;
  int cnt = 0;
  logic pend = 1'b0;
  logic [2*BW-1:0] gold_cur = '0;

  always #2 clk = ~clk;

  chk_guided_corrector i_chk_guided_corrector (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_par(in_par), .in_mode(in_mode),
    .chk_req(chk_req), .chk_data(chk_data),
    .chk_rsp_valid(chk_rsp_valid), .chk_rsp_pass(chk_rsp_pass),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_uncorr(out_uncorr), .out_attempts(out_attempts)
  );

  // integrity-check stub: passes only the intact block, answers after lat_cur cycles
  always @(negedge clk) begin
    chk_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        chk_rsp_valid = 1'b1;
        chk_rsp_pass  = pend;
      end
    end
    if (rst_n && chk_req) begin
      if (cnt > 0) overlap++;
      nreq++;
      pend = (chk_data == gold_cur);
      cnt  = lat_cur;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic check(input string req, input string what,
                       input logic [2*BW-1:0] act, input logic [2*BW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*BW-1:0] gen_gold(input int s);
    logic [2*BW-1:0] g;
    for (int w = 0; w < 16; w++)
      g[32*w +: 32] = (32'h9E3779B9 * (w + 1)) ^ (32'(s) * 32'h01000193) ^ 32'h5A5A1234;
    return g;
  endfunction

  function automatic logic [3:0] lane_par(input logic [BW-1:0] h);
    logic [3:0] p = '0;
    for (int l = 0; l < BW/4; l++) p ^= h[4*l +: 4];
    return p;
  endfunction

  task automatic send_beat(input logic [BW-1:0] d, input logic [3:0] p, input logic m);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_par = p; in_mode = m;
    forever begin
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_block(input string tag, input logic m, input logic [2*BW-1:0] gold,
                           input logic [2*BW-1:0] bad, input int lat, input logic bubble,
                           input logic [15:0] exp_att, input logic exp_unc);
    logic [2*BW-1:0] held;
    gold_cur = gold;
    lat_cur  = lat;
    nreq     = 0;
    overlap  = 0;
    send_beat(bad[BW-1:0], lane_par(gold[BW-1:0]), m);
    if (bubble) repeat (2) @(negedge clk);
    send_beat(bad[2*BW-1:BW], lane_par(gold[2*BW-1:BW]), m);
    while (!out_valid) @(negedge clk);
    check(tag, "uncorrectable flag (R7/R8)", 512'(out_uncorr), 512'(exp_unc));
    check(tag, "data (R7/R8)", out_data, exp_unc ? bad : gold);
    check(tag, "attempt count", 512'(out_attempts), 512'(exp_att));
    check("R2/R9", "requests", 512'(nreq), 512'(int'(exp_att) + 1));
    check("R9", "overlapping requests", 512'(overlap), 512'(0));
    held = out_data;
    repeat (3) @(negedge clk);
    check("R10", "valid held", 512'(out_valid), 512'(1));
    check("R10", "data held", out_data, held);
    check("R1", "in_ready low while result waits", 512'(in_ready), 512'(0));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R10", "valid drops after take", 512'(out_valid), 512'(0));
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 12:         return "R2";
      2, 3, 4, 8, 15: return "R6";
      6, 14:         return "R7";
      13:            return "R5";
      default:       return VTAB[i].mode ? "R4" : "R3";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset in_ready", 512'(in_ready), 512'(1));
    check("R1", "reset out_valid", 512'(out_valid), 512'(0));
    check("R9", "reset chk_req", 512'(chk_req), 512'(0));
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2*BW-1:0] g, b;
      g = gen_gold(i);
      b = g ^ (512'(VTAB[i].ka) << VTAB[i].pa) ^ (512'(VTAB[i].kb) << VTAB[i].pb);
      run_block(tag_of(i), VTAB[i].mode, g, b, 4 + (i % 5), logic'(i % 2),
                VTAB[i].att, VTAB[i].unc);
    end

    // reset clears the hints: bit 5 now needs the full walk from 0
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset in_ready again", 512'(in_ready), 512'(1));
    check("R1", "reset out_valid again", 512'(out_valid), 512'(0));
    rst_n = 1'b1;
    begin
      logic [2*BW-1:0] g;
      g = gen_gold(99);
      run_block("R6", 1'b0, g, g ^ (512'(1) << 5), 8, 1'b0, 16'd6, 1'b0);
      // chip-mode hint also cleared: lane 9 of second half, no hint -> 10 attempts
      run_block("R6", 1'b1, g, g ^ (512'(4'h3) << (256 + 36)), 5, 1'b1, 16'd10, 1'b0);
    end
    report();
  end
endmodule